// File: doc/BRIEF.md
# USB Host Controller Control and Status Register Block

This block is a small bank of memory-mapped registers that sits next to a USB host controller. It holds the static configuration the controller samples: a four-bit bus filter bypass, five port and hub option bits, a six-bit frame length adjust value, a byte-order select, a coherency select, a bus master enable and one spare 32-bit word. Each setting is driven straight out on its own pins. Software reaches the bank over an APB-style 32-bit bus with zero wait states. Writes take effect at the clock edge of the access phase. Read data and the error response are valid during the access phase.

The block also holds a two-source error interrupt unit. Bit 0 of the status register records address decode errors and bit 1 records host system errors. Status bits are set by one-cycle event pulses from hardware, or by any bus access that falls on a hole in the window. Software clears a status bit by writing a one to it. The interrupt mask cannot be written directly. Writing ones to the enable strobe register unmasks sources, and writing ones to the disable strobe register masks them. A single registered, level-sensitive interrupt line reports any status bit that is set and not masked.

Top module: `usbctl_regs`

## Requirements
- R1: After reset, frame length adjust reads 0x20, bus master enable reads 1 and the mask at 0x68 reads 0x3. Every other register, every other configuration output, the interrupt output and the error response are zero.
- R2: Reserved bits read as zero and ignore writes. The usable bits are 3:0 at 0x30, 4:0 at 0x34 and 5:0 at 0x38. At 0x40, 0x44, 0x48 and 0x60 only bit 0 is usable.
- R3: A write to a configuration register is visible on readback and on its output pin from the next cycle. The port bits at 0x34 are ordered from bit 0 upward: hub permanent attach, power control present, MSI enable, PCI command write SMI, BAR write SMI.
- R4: In the status register at 0x64, bit 0 is address decode error and bit 1 is host system error. Writing a one clears the bit, and writing a zero leaves it unchanged.
- R5: The mask at 0x68 ignores direct writes. A one written to 0x6C clears the matching mask bit, and a one written to 0x70 sets it. All other mask bits hold.
- R6: 0x6C and 0x70 store nothing and always read as zero.
- R7: The interrupt output equals the OR of (status AND NOT mask) as it stood one clock earlier.
- R8: A one-cycle pulse on the host-error or decode-error event input sets the matching status bit. A set and a software clear in the same cycle leave the bit set.
- R9: An access to an offset in the 128-byte window that has no register, or an access with paddr[1:0] not zero, reads as zero, changes no register and sets status bit 0.
- R10: Such an undefined access asserts pslverr during its access phase only while bit 0 of 0x60 is set. Defined accesses never assert pslverr.
- R11: The word at 0x78 stores and returns all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 7 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Error response in the access phase |
| hse_evt | input | 1 | Host system error event pulse |
| ade_evt | input | 1 | Address decode error event pulse |
| irq | output | 1 | Level interrupt |
| filt_bypass | output | 4 | Bus filter bypass bits |
| port_cfg | output | 5 | Port and hub option bits |
| fladj | output | 6 | Frame length adjust |
| big_endian | output | 1 | Byte order select |
| coherent | output | 1 | Coherent path select |
| bus_master_en | output | 1 | Bus master enable |
| spare_word | output | 32 | Spare 32-bit register |

## Verification
A status bit can receive a hardware set event and a software write-one clear in the same clock. The bench provokes this by raising the host-error event pulse during the access phase of a clear write to 0x64. It then reads the status back and expects the bit still set. The same collision happens when an undefined access sets bit 0 while software wants that bit clear. The bench checks that both the readback and the following interrupt level show the set taking priority.

// File: rtl/usbctl_pkg.sv
package usbctl_pkg;
  localparam int DATA_W  = 32;
  localparam int FILT_W  = 4;
  localparam int PORT_W  = 5;
  localparam int FLADJ_W = 6;
  localparam int IRQ_N   = 2;
  localparam int SRC_ADE = 0;
  localparam int SRC_HSE = 1;

  localparam logic [FLADJ_W-1:0] FLADJ_RST = 6'h20;

  // byte offsets of the implemented registers
  localparam int OFF_FILT   = 'h30;
  localparam int OFF_PORT   = 'h34;
  localparam int OFF_FLADJ  = 'h38;
  localparam int OFF_ENDIAN = 'h40;
  localparam int OFF_COH    = 'h44;
  localparam int OFF_BME    = 'h48;
  localparam int OFF_ERRCTL = 'h60;
  localparam int OFF_STAT   = 'h64;
  localparam int OFF_MASK   = 'h68;
  localparam int OFF_EN     = 'h6C;
  localparam int OFF_DIS    = 'h70;
  localparam int OFF_SPARE  = 'h78;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_FILT, SEL_PORT, SEL_FLADJ, SEL_ENDIAN, SEL_COH, SEL_BME,
    SEL_ERRCTL, SEL_STAT, SEL_MASK, SEL_EN, SEL_DIS, SEL_SPARE
  } reg_sel_e;
endpackage

// File: rtl/usbctl_decode.sv
module usbctl_decode
  import usbctl_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              hit
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      case (word)
        WORD_W'(OFF_FILT   >> 2): sel = SEL_FILT;
        WORD_W'(OFF_PORT   >> 2): sel = SEL_PORT;
        WORD_W'(OFF_FLADJ  >> 2): sel = SEL_FLADJ;
        WORD_W'(OFF_ENDIAN >> 2): sel = SEL_ENDIAN;
        WORD_W'(OFF_COH    >> 2): sel = SEL_COH;
        WORD_W'(OFF_BME    >> 2): sel = SEL_BME;
        WORD_W'(OFF_ERRCTL >> 2): sel = SEL_ERRCTL;
        WORD_W'(OFF_STAT   >> 2): sel = SEL_STAT;
        WORD_W'(OFF_MASK   >> 2): sel = SEL_MASK;
        WORD_W'(OFF_EN     >> 2): sel = SEL_EN;
        WORD_W'(OFF_DIS    >> 2): sel = SEL_DIS;
        WORD_W'(OFF_SPARE  >> 2): sel = SEL_SPARE;
        default:                  sel = SEL_NONE;
      endcase
    end
  end

  assign hit = (sel != SEL_NONE);
endmodule

// File: rtl/usbctl_cfg.sv
module usbctl_cfg
  import usbctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  reg_sel_e           sel,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FILT_W-1:0]  filt_q,
  output logic [PORT_W-1:0]  port_q,
  output logic [FLADJ_W-1:0] fladj_q,
  output logic               endian_q,
  output logic               coh_q,
  output logic               bme_q,
  output logic               errctl_q,
  output logic [DATA_W-1:0]  spare_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q   <= '0;
      port_q   <= '0;
      fladj_q  <= FLADJ_RST;
      endian_q <= 1'b0;
      coh_q    <= 1'b0;
      bme_q    <= 1'b1;
      errctl_q <= 1'b0;
      spare_q  <= '0;
    end else if (wr) begin
      // only the usable low bits are stored; the rest are dropped
      case (sel)
        SEL_FILT:   filt_q   <= wdata[FILT_W-1:0];
        SEL_PORT:   port_q   <= wdata[PORT_W-1:0];
        SEL_FLADJ:  fladj_q  <= wdata[FLADJ_W-1:0];
        SEL_ENDIAN: endian_q <= wdata[0];
        SEL_COH:    coh_q    <= wdata[0];
        SEL_BME:    bme_q    <= wdata[0];
        SEL_ERRCTL: errctl_q <= wdata[0];
        SEL_SPARE:  spare_q  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/usbctl_irq.sv
module usbctl_irq
  import usbctl_pkg::*;
#(
  parameter int N = IRQ_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  reg_sel_e     sel,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] evt,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] mask_q,
  output logic         irq_q
);
  for (genvar i = 0; i < N; i++) begin : g_src
    // status: a hardware event has priority over a write-one clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   stat_q[i] <= 1'b0;
      else if (evt[i])                              stat_q[i] <= 1'b1;
      else if (wr && sel == SEL_STAT && wdata[i])   stat_q[i] <= 1'b0;
    end

    // mask: only moved by the enable and disable strobes
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   mask_q[i] <= 1'b1;
      else if (wr && sel == SEL_EN && wdata[i])     mask_q[i] <= 1'b0;
      else if (wr && sel == SEL_DIS && wdata[i])    mask_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat_q & ~mask_q);
  end
endmodule

// File: rtl/usbctl_regs.sv
module usbctl_regs
  import usbctl_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  output logic               pslverr,
  input  logic               hse_evt,
  input  logic               ade_evt,
  output logic               irq,
  output logic [FILT_W-1:0]  filt_bypass,
  output logic [PORT_W-1:0]  port_cfg,
  output logic [FLADJ_W-1:0] fladj,
  output logic               big_endian,
  output logic               coherent,
  output logic               bus_master_en,
  output logic [DATA_W-1:0]  spare_word
);
  reg_sel_e           sel;
  logic               hit;
  logic               acc;
  logic               wr;
  logic               errctl_q;
  logic [IRQ_N-1:0]   evt;
  logic [IRQ_N-1:0]   stat_q;
  logic [IRQ_N-1:0]   mask_q;

  assign acc = psel && penable;
  assign wr  = acc && pwrite && hit;

  usbctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (paddr),
    .sel  (sel),
    .hit  (hit)
  );

  usbctl_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr),
    .sel      (sel),
    .wdata    (pwdata),
    .filt_q   (filt_bypass),
    .port_q   (port_cfg),
    .fladj_q  (fladj),
    .endian_q (big_endian),
    .coh_q    (coherent),
    .bme_q    (bus_master_en),
    .errctl_q (errctl_q),
    .spare_q  (spare_word)
  );

  always_comb begin
    evt          = '0;
    evt[SRC_HSE] = hse_evt;
    evt[SRC_ADE] = ade_evt || (acc && !hit);
  end

  usbctl_irq #(.N(IRQ_N)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr),
    .sel    (sel),
    .wdata  (pwdata[IRQ_N-1:0]),
    .evt    (evt),
    .stat_q (stat_q),
    .mask_q (mask_q),
    .irq_q  (irq)
  );

  always_comb begin
    prdata = '0;
    case (sel)
      SEL_FILT:   prdata[FILT_W-1:0]  = filt_bypass;
      SEL_PORT:   prdata[PORT_W-1:0]  = port_cfg;
      SEL_FLADJ:  prdata[FLADJ_W-1:0] = fladj;
      SEL_ENDIAN: prdata[0]           = big_endian;
      SEL_COH:    prdata[0]           = coherent;
      SEL_BME:    prdata[0]           = bus_master_en;
      SEL_ERRCTL: prdata[0]           = errctl_q;
      SEL_STAT:   prdata[IRQ_N-1:0]   = stat_q;
      SEL_MASK:   prdata[IRQ_N-1:0]   = mask_q;
      SEL_SPARE:  prdata              = spare_word;
      default:    prdata              = '0;
    endcase
  end

  assign pslverr = acc && !hit && errctl_q;
endmodule

// File: rtl/usbctl_regs_chk.sv
module usbctl_regs_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       prdata,
  input logic              pslverr,
  input logic              hse_evt,
  input logic              irq,
  input logic [1:0]        stat,
  input logic [1:0]        mask
);
  logic acc;
  logic defined;
  logic strobe_wr;

  assign acc = psel && penable;

  always_comb begin
    case (paddr)
      ADDR_W'('h30), ADDR_W'('h34), ADDR_W'('h38), ADDR_W'('h40),
      ADDR_W'('h44), ADDR_W'('h48), ADDR_W'('h60), ADDR_W'('h64),
      ADDR_W'('h68), ADDR_W'('h6C), ADDR_W'('h70), ADDR_W'('h78):
        defined = 1'b1;
      default: defined = 1'b0;
    endcase
  end

  assign strobe_wr = acc && pwrite &&
                     (paddr == ADDR_W'('h6C) || paddr == ADDR_W'('h70));

  p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(stat & ~mask))));

  p_evt_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hse_evt |=> stat[1]);

  p_hole_sets_ade_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !defined) |=> stat[0]);

  p_mask_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_wr |=> $stable(mask));

  p_slverr_hole_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (acc && !defined));

  p_filt_rsv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pwrite && paddr == ADDR_W'('h30)) |-> (prdata[31:4] == 28'd0));

  p_strobe_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pwrite && (paddr == ADDR_W'('h6C) || paddr == ADDR_W'('h70)))
      |-> (prdata == 32'd0));
endmodule

bind usbctl_regs usbctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .prdata  (prdata),
  .pslverr (pslverr),
  .hse_evt (hse_evt),
  .irq     (irq),
  .stat    (stat_q),
  .mask    (mask_q)
);

// File: tb/usbctl_regs_bench.sv
module usbctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [6:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pslverr;
  logic        hse_evt = 1'b0, ade_evt = 1'b0;
  logic        irq;
  logic [3:0]  filt_bypass;
  logic [4:0]  port_cfg;
  logic [5:0]  fladj;
  logic        big_endian, coherent, bus_master_en;
  logic [31:0] spare_word;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  usbctl_regs u_usbctl_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
    .hse_evt(hse_evt), .ade_evt(ade_evt), .irq(irq),
    .filt_bypass(filt_bypass), .port_cfg(port_cfg), .fladj(fladj),
    .big_endian(big_endian), .coherent(coherent),
    .bus_master_en(bus_master_en), .spare_word(spare_word)
  );

  typedef struct packed {
    bit        wr;
    bit [6:0]  addr;
    bit [31:0] data;   // write data, or expected read data
    bit [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 7'h38, 32'h0000_0020, 8'd1},
    '{1'b0, 7'h48, 32'h0000_0001, 8'd1},
    '{1'b0, 7'h68, 32'h0000_0003, 8'd1},
    '{1'b1, 7'h30, 32'hFFFF_FFFF, 8'd2},
    '{1'b0, 7'h30, 32'h0000_000F, 8'd2},
    '{1'b1, 7'h34, 32'hFFFF_FFFF, 8'd2},
    '{1'b0, 7'h34, 32'h0000_001F, 8'd2},
    '{1'b1, 7'h38, 32'hFFFF_FFC5, 8'd2},
    '{1'b0, 7'h38, 32'h0000_0005, 8'd2},
    '{1'b1, 7'h40, 32'hFFFF_FFFF, 8'd2},
    '{1'b0, 7'h40, 32'h0000_0001, 8'd2},
    '{1'b1, 7'h44, 32'hFFFF_FFFE, 8'd2},
    '{1'b0, 7'h44, 32'h0000_0000, 8'd2},
    '{1'b1, 7'h78, 32'hDEAD_BEEF, 8'd11},
    '{1'b0, 7'h78, 32'hDEAD_BEEF, 8'd11},
    '{1'b1, 7'h68, 32'h0000_0000, 8'd5},
    '{1'b0, 7'h68, 32'h0000_0003, 8'd5},
    '{1'b1, 7'h6C, 32'h0000_0001, 8'd5},
    '{1'b0, 7'h68, 32'h0000_0002, 8'd5},
    '{1'b0, 7'h6C, 32'h0000_0000, 8'd6},
    '{1'b1, 7'h70, 32'hFFFF_FFFF, 8'd5},
    '{1'b0, 7'h70, 32'h0000_0000, 8'd6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one APB transfer; returns read data and the error response of the access phase
  task automatic bus(input bit wr, input logic [6:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic err);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd = prdata; err = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    logic        err;

    repeat (3) @(negedge clk);
    // R1 reset state at the pins
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 fladj", {26'd0, fladj}, 32'h20);
    check("R1 bme", {31'd0, bus_master_en}, 32'd1);
    check("R1 cfg zero", {filt_bypass, port_cfg, big_endian, coherent, spare_word[7:0]}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus(TBL[i].wr, TBL[i].addr, TBL[i].data, rd, err);
      if (!TBL[i].wr) check($sformatf("R%0d vec%0d", TBL[i].req, i), rd, TBL[i].data);
    end

    // R3 port bit order and outputs
    bus(1'b1, 7'h34, 32'h0000_0009, rd, err);
    check("R3 port_cfg", {27'd0, port_cfg}, 32'h9);
    check("R3 hub attach bit0", {31'd0, port_cfg[0]}, 32'd1);
    bus(1'b1, 7'h48, 32'h0, rd, err);
    check("R3 bme pin", {31'd0, bus_master_en}, 32'd0);
    check("R11 spare pin", spare_word, 32'hDEAD_BEEF);

    // R9 undefined offsets: zero data, no write, decode error recorded
    bus(1'b1, 7'h3C, 32'h1234_5678, rd, err);
    bus(1'b0, 7'h3C, 32'h0, rd, err);
    check("R9 hole reads zero", rd, 32'd0);
    bus(1'b1, 7'h31, 32'h0000_0000, rd, err);
    bus(1'b0, 7'h30, 32'h0, rd, err);
    check("R9 misaligned write ignored", rd, 32'hF);
    bus(1'b0, 7'h64, 32'h0, rd, err);
    check("R9 ade status", rd, 32'h1);

    // R4 write-one clear
    bus(1'b1, 7'h64, 32'h0, rd, err);
    bus(1'b0, 7'h64, 32'h0, rd, err);
    check("R4 write zero keeps", rd, 32'h1);
    bus(1'b1, 7'h64, 32'h1, rd, err);
    bus(1'b0, 7'h64, 32'h0, rd, err);
    check("R4 write one clears", rd, 32'h0);

    // R8 event pulse
    @(negedge clk); hse_evt = 1'b1;
    @(negedge clk); hse_evt = 1'b0;
    bus(1'b0, 7'h64, 32'h0, rd, err);
    check("R8 hse sets", rd, 32'h2);
    check("R7 masked no irq", {31'd0, irq}, 32'd0);

    // R7 irq one cycle after unmask
    bus(1'b1, 7'h6C, 32'h2, rd, err);
    check("R7 irq not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R7 irq raised", {31'd0, irq}, 32'd1);
    bus(1'b1, 7'h70, 32'h2, rd, err);
    @(negedge clk);
    check("R5 disable masks irq", {31'd0, irq}, 32'd0);
    bus(1'b1, 7'h6C, 32'h2, rd, err);

    // R8 collision: clear and event together
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = 7'h64; pwdata = 32'h2;
    @(negedge clk);
    penable = 1'b1; hse_evt = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; hse_evt = 1'b0;
    bus(1'b0, 7'h64, 32'h0, rd, err);
    check("R8 set wins", rd, 32'h2);
    check("R8 irq stays", {31'd0, irq}, 32'd1);
    bus(1'b1, 7'h64, 32'h2, rd, err);
    @(negedge clk);
    check("R7 irq drops", {31'd0, irq}, 32'd0);

    // R10 error response
    bus(1'b0, 7'h4C, 32'h0, rd, err);
    check("R10 no slverr when off", {31'd0, err}, 32'd0);
    bus(1'b1, 7'h60, 32'h1, rd, err);
    bus(1'b0, 7'h4C, 32'h0, rd, err);
    check("R10 slverr on hole", {31'd0, err}, 32'd1);
    bus(1'b0, 7'h60, 32'h0, rd, err);
    check("R10 no slverr defined", {31'd0, err}, 32'd0);
    check("R10 errctl readback", rd, 32'h1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule